// File: doc/BRIEF.md
# Prescaled Counter Timer with Selectable Hardware Clear

This block is an up-counting timer. A prescaler divides the timer clock, so the count advances once every `prescale + 1` clocks while the timer is running. When the count equals a programmable period value, a one-cycle match pulse is raised. A 2-bit mode input decides which event, if any, forces the counter back to zero. In free mode the count runs to all ones and wraps. The other modes clear it on an external clear line held at its active level, on a start event, or on period match alone. A clear always takes precedence over counting, starting and stopping.

The external clear line is asynchronous to the timer clock. It passes through a two-stage synchronizer, and a polarity input selects which level counts as active. A rising edge on the start request sets the running flag, and the stop request clears it. A zero flag pulses for one clock whenever the count falls from a nonzero value to zero. The rules for a clear that lands near a period match are fixed. A clear inside the match interval, before the prescaler rolls over, suppresses the pulse. A clear on the same clock as the pulse leaves the pulse intact.

Top module: `ctmr_timer`

## Requirements
- R1: `clr_mode` encoding: 0 = free, 1 = level clear, 2 = start-event clear, 3 = match clear. In mode 0 the count wraps from all ones to zero, and a match does not clear it.
- R2: A rising edge of `start_req` sets `running`. `stop_req` clears it, and a start edge wins over a stop on the same clock. While running, the count advances once every `prescale + 1` clocks.
- R3: In mode 1 the clear line is active when `ext_clr` is low with `clr_pol` = 0, or high with `clr_pol` = 1. Two clocks after the line reaches its active level, count and prescaler are held at zero and `running` is held at 0. Start edges are ignored for as long as the level lasts.
- R4: In mode 2 each start event clears count and prescaler and sets `running`. A start event is a rising edge of `start_req` or the leading edge of the synchronized active clear level. A held level causes only one clear.
- R5: In modes 1 to 3, a prescaler rollover with count equal to `period` clears the count. In every mode that rollover raises `match_pulse` for one clock, on the same edge.
- R6: `zero_flag` pulses for one clock when the count changes from nonzero to zero. It stays 0 when a clear hits a count that is already zero.
- R7: A level or start-event clear that arrives while count equals `period`, but before the prescaler rolls over, clears count and prescaler at once, and no `match_pulse` follows.
- R8: A level or start-event clear on the same clock as a matching rollover still produces `match_pulse`.
- R9: A synchronous active-high `rst` sets the count to zero and drops `running`, `zero_flag` and `match_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start request; its rising edge is a start event |
| stop_req | input | 1 | Stop request, level |
| ext_clr | input | 1 | Asynchronous external clear line |
| clr_pol | input | 1 | 0: `ext_clr` active low; 1: active high |
| clr_mode | input | 2 | Clear source selector (see R1) |
| prescale | input | PW | Prescaler limit; divide ratio is value + 1 |
| period | input | W | Period compare value |
| count | output | W | Current count |
| running | output | 1 | Timer running flag |
| zero_flag | output | 1 | One-clock pulse when the count drops to zero |
| match_pulse | output | 1 | One-clock pulse on a period match at rollover |

## Verification
On every clock, the assertions check the following. A held level clear keeps the count and the running flag at zero. A zero flag only follows a nonzero count. Every match pulse has a matching rollover behind it. A matching rollover clears the count in the clearing modes. In free mode each rollover adds one, wrapping at all ones. Several behaviours are shown only by the bench's scenarios, because they depend on input histories rather than on one clock. These are the two-clock synchronizer latency and both polarities. They also include start edges being ignored under a level clear and the single clear from a held level. The last of them is the difference between a clear inside the match interval (no pulse) and one on the rollover clock (pulse kept).

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        CM_FREE  = 2'd0,
        CM_LEVEL = 2'd1,
        CM_START = 2'd2,
        CM_MATCH = 2'd3
    } clr_mode_e;

    typedef struct packed {
        logic level_clr;
        logic event_clr;
    } clr_req_t;

    typedef struct packed {
        logic active;
        logic leading;
    } line_state_t;

    function automatic logic mode_clears_on_match(clr_mode_e m);
        return m != CM_FREE;
    endfunction

    function automatic logic line_is_active(logic sample, logic pol);
        return pol ? sample : ~sample;
    endfunction

endpackage

// File: rtl/ctmr_line_sync.sv
module ctmr_line_sync
    import ctmr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        line_in,
    input  logic        pol,
    output line_state_t state
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              active_q;
    logic              active_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], line_in};
        end
    end

    assign active_now = line_is_active(chain[LAST], pol);

    // Previous level resets high so that leaving reset never looks like an edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b1;
        end else begin
            active_q <= active_now;
        end
    end

    always_comb begin
        state.active  = active_now;
        state.leading = active_now & ~active_q;
    end
endmodule

// File: rtl/ctmr_run_ctl.sv
module ctmr_run_ctl
    import ctmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_req,
    input  logic        stop_req,
    input  clr_mode_e   mode,
    input  line_state_t line,
    output clr_req_t    clr,
    output logic        running
);
    logic start_q;
    logic start_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
        end else begin
            start_q <= start_req;
        end
    end

    assign start_edge = start_req & ~start_q;

    always_comb begin
        clr.level_clr = (mode == CM_LEVEL) & line.active;
        clr.event_clr = (mode == CM_START) & (start_edge | line.leading);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
        end else if (clr.level_clr) begin
            running <= 1'b0;
        end else if (clr.event_clr || start_edge) begin
            running <= 1'b1;
        end else if (stop_req) begin
            running <= 1'b0;
        end
    end
endmodule

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          running,
    input  logic [PW-1:0] limit,
    output logic          tick
);
    logic [PW-1:0] div_cnt;

    assign tick = running & (div_cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_cnt <= '0;
        end else if (tick) begin
            div_cnt <= '0;
        end else if (running) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ctmr_count_core.sv
module ctmr_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic         match_clr_en,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         zero_flag,
    output logic         match_pulse
);
    localparam logic [W-1:0] ZERO = '0;

    logic         hit;
    logic [W-1:0] count_n;

    assign hit = (count == period);

    always_comb begin
        count_n = count;
        if (clr) begin
            count_n = ZERO;
        end else if (tick) begin
            count_n = (hit && match_clr_en) ? ZERO : count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count       <= ZERO;
            zero_flag   <= 1'b0;
            match_pulse <= 1'b0;
        end else begin
            count       <= count_n;
            zero_flag   <= (count != ZERO) && (count_n == ZERO);
            match_pulse <= tick & hit;
        end
    end
endmodule

// File: rtl/ctmr_timer.sv
module ctmr_timer
    import ctmr_pkg::*;
#(
    parameter int W           = 16,
    parameter int PW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          stop_req,
    input  logic          ext_clr,
    input  logic          clr_pol,
    input  logic [1:0]    clr_mode,
    input  logic [PW-1:0] prescale,
    input  logic [W-1:0]  period,
    output logic [W-1:0]  count,
    output logic          running,
    output logic          zero_flag,
    output logic          match_pulse
);
    clr_mode_e   mode;
    line_state_t line;
    clr_req_t    clr;
    logic        tick;
    logic        any_clr;
    logic        level_clr;
    logic        event_clr;

    assign mode      = clr_mode_e'(clr_mode);
    assign level_clr = clr.level_clr;
    assign event_clr = clr.event_clr;
    assign any_clr   = level_clr | event_clr;

    ctmr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (ext_clr),
        .pol     (clr_pol),
        .state   (line)
    );

    ctmr_run_ctl u_run (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .stop_req  (stop_req),
        .mode      (mode),
        .line      (line),
        .clr       (clr),
        .running   (running)
    );

    ctmr_prescaler #(.PW(PW)) u_div (
        .clk     (clk),
        .rst     (rst),
        .clr     (any_clr),
        .running (running),
        .limit   (prescale),
        .tick    (tick)
    );

    ctmr_count_core #(.W(W)) u_core (
        .clk          (clk),
        .rst          (rst),
        .clr          (any_clr),
        .tick         (tick),
        .match_clr_en (mode_clears_on_match(mode)),
        .period       (period),
        .count        (count),
        .zero_flag    (zero_flag),
        .match_pulse  (match_pulse)
    );
endmodule

// File: rtl/ctmr_timer_chk.sv
module ctmr_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   clr_mode,
    input logic [W-1:0] count,
    input logic [W-1:0] period,
    input logic         running,
    input logic         zero_flag,
    input logic         match_pulse,
    input logic         tick,
    input logic         level_clr
);
    assert_level_hold_R3: assert property (@(posedge clk) disable iff (rst)
        level_clr |=> (count == '0 && !running));

    assert_zero_after_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        zero_flag |-> (count == '0 && $past(count) != '0));

    assert_pulse_has_match_R5: assert property (@(posedge clk) disable iff (rst)
        match_pulse |-> ($past(tick) && $past(count) == $past(period)));

    assert_match_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && count == period && clr_mode != 2'd0) |=> count == '0);

    assert_free_advance_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && clr_mode == 2'd0) |=> count == W'($past(count) + 1'b1));

    assert_reset_state_R9: assert property (@(posedge clk)
        $past(rst) |-> (!running && !zero_flag && !match_pulse));
endmodule

bind ctmr_timer ctmr_timer_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .clr_mode    (clr_mode),
    .count       (count),
    .period      (period),
    .running     (running),
    .zero_flag   (zero_flag),
    .match_pulse (match_pulse),
    .tick        (tick),
    .level_clr   (level_clr)
);

// File: tb/ctmr_timer_tb_top.sv
module ctmr_timer_tb_top;
    localparam int W  = 8;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_req = 1'b0;
    logic          stop_req = 1'b0;
    logic          ext_clr = 1'b1;
    logic          clr_pol = 1'b0;
    logic [1:0]    clr_mode = 2'd0;
    logic [PW-1:0] prescale = '0;
    logic [W-1:0]  period = '0;
    logic [W-1:0]  count;
    logic          running;
    logic          zero_flag;
    logic          match_pulse;

    always #2.5 clk = ~clk;

    ctmr_timer #(.W(W), .PW(PW)) dut_i (
        .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
        .ext_clr(ext_clr), .clr_pol(clr_pol), .clr_mode(clr_mode),
        .prescale(prescale), .period(period), .count(count),
        .running(running), .zero_flag(zero_flag), .match_pulse(match_pulse)
    );

    typedef struct {
        int          cyc;
        logic [W-1:0] cnt;
        bit          run;
        bit          zf;
        bit          mp;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares every expected item on the cycle it names.
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                total++;
                if (count !== q[i].cnt || running !== q[i].run ||
                    zero_flag !== q[i].zf || match_pulse !== q[i].mp) begin
                    bad++;
                    $display("FAIL %s: cnt=%0d run=%0d zf=%0d mp=%0d expected cnt=%0d run=%0d zf=%0d mp=%0d",
                             q[i].tag, count, running, zero_flag, match_pulse,
                             q[i].cnt, q[i].run, q[i].zf, q[i].mp);
                end
                q.delete(i);
            end
        end
    end

    task automatic expect_at(int k, logic [W-1:0] c, bit r, bit z, bit p, string tag);
        exp_t e;
        e.cyc = cyc + k; e.cnt = c; e.run = r; e.zf = z; e.mp = p; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart(logic [1:0] m, logic pol, logic idle, logic [PW-1:0] ps, logic [W-1:0] per);
        @(negedge clk);
        start_req = 1'b0; stop_req = 1'b0;
        clr_mode = m; clr_pol = pol; ext_clr = idle; prescale = ps; period = per;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(4);
    endtask

    initial begin
        // Free-running match mode, prescale 0, period 3
        restart(2'd3, 1'b0, 1'b1, 4'd0, 8'd3);
        start_req = 1'b1;
        expect_at(1, 8'd0, 1, 0, 0, "R2 start edge sets running");
        expect_at(2, 8'd1, 1, 0, 0, "R2 first advance");
        expect_at(4, 8'd3, 1, 0, 0, "R2 reach period");
        expect_at(5, 8'd0, 1, 1, 1, "R5 match clear with pulse");
        expect_at(6, 8'd1, 1, 0, 0, "R6 zero flag one clock");
        step(6);
        stop_req = 1'b1;
        expect_at(1, 8'd2, 0, 0, 0, "R2 stop drops running");
        expect_at(3, 8'd2, 0, 0, 0, "R2 count holds when stopped");
        step(1);
        stop_req = 1'b0;
        step(3);
        rst = 1'b1;
        expect_at(1, 8'd0, 0, 0, 0, "R9 reset state");
        step(2);

        // Prescaler divide by 3
        restart(2'd3, 1'b0, 1'b1, 4'd2, 8'd200);
        start_req = 1'b1;
        expect_at(3, 8'd0, 1, 0, 0, "R2 prescale hold");
        expect_at(4, 8'd1, 1, 0, 0, "R2 prescale first tick");
        expect_at(6, 8'd1, 1, 0, 0, "R2 prescale between ticks");
        expect_at(7, 8'd2, 1, 0, 0, "R2 prescale second tick");
        step(8);

        // Free mode: match pulse without clear, wrap at all ones
        restart(2'd0, 1'b0, 1'b1, 4'd0, 8'd5);
        start_req = 1'b1;
        expect_at(7, 8'd6, 1, 0, 1, "R1 free mode pulse no clear");
        expect_at(256, 8'd255, 1, 0, 0, "R1 full scale");
        expect_at(257, 8'd0, 1, 1, 0, "R1 wrap to zero");
        expect_at(258, 8'd1, 1, 0, 0, "R1 after wrap");
        step(260);

        // Level clear, active low
        restart(2'd1, 1'b0, 1'b1, 4'd0, 8'd100);
        start_req = 1'b1;
        step(10);
        ext_clr = 1'b0;
        start_req = 1'b0;
        expect_at(2, 8'd11, 1, 0, 0, "R3 sync latency");
        expect_at(3, 8'd0, 0, 1, 0, "R3 level clear active low");
        expect_at(4, 8'd0, 0, 0, 0, "R6 no flag while already zero");
        step(5);
        start_req = 1'b1;
        expect_at(1, 8'd0, 0, 0, 0, "R3 start ignored under level");
        expect_at(3, 8'd0, 0, 0, 0, "R3 still held");
        step(3);
        ext_clr = 1'b1;
        expect_at(4, 8'd0, 0, 0, 0, "R3 no late start after release");
        step(5);

        // Level clear, active high
        restart(2'd1, 1'b1, 1'b0, 4'd0, 8'd100);
        start_req = 1'b1;
        step(5);
        ext_clr = 1'b1;
        expect_at(2, 8'd6, 1, 0, 0, "R3 polarity latency");
        expect_at(3, 8'd0, 0, 1, 0, "R3 level clear active high");
        step(4);

        // Start-event clear via start request
        restart(2'd2, 1'b0, 1'b1, 4'd0, 8'd4);
        start_req = 1'b1;
        expect_at(1, 8'd0, 1, 0, 0, "R4 start clears and runs");
        expect_at(5, 8'd4, 1, 0, 0, "R4 one extra clock to match");
        expect_at(6, 8'd0, 1, 1, 1, "R5 start mode match clear");
        expect_at(7, 8'd1, 1, 0, 0, "R4 held start no reclear");
        step(7);
        start_req = 1'b0;
        step(1);
        start_req = 1'b1;
        expect_at(1, 8'd0, 1, 1, 0, "R4 new start edge clears");
        expect_at(2, 8'd1, 1, 0, 0, "R4 count resumes");
        step(3);

        // Start-event clear via leading edge of the clear line
        restart(2'd2, 1'b0, 1'b1, 4'd0, 8'd50);
        start_req = 1'b1;
        step(10);
        ext_clr = 1'b0;
        expect_at(3, 8'd0, 1, 1, 0, "R4 leading edge clears");
        expect_at(6, 8'd3, 1, 0, 0, "R4 held level clears once");
        step(7);

        // Clear inside the match interval: no pulse
        restart(2'd2, 1'b0, 1'b1, 4'd3, 8'd2);
        start_req = 1'b1;
        step(1);
        start_req = 1'b0;
        expect_at(9, 8'd2, 1, 0, 0, "R7 at period before rollover");
        step(9);
        start_req = 1'b1;
        expect_at(1, 8'd0, 1, 1, 0, "R7 immediate clear");
        expect_at(3, 8'd0, 1, 0, 0, "R7 pulse suppressed");
        expect_at(5, 8'd1, 1, 0, 0, "R7 prescaler restarted");
        step(6);

        // Clear on the rollover clock: pulse kept
        restart(2'd2, 1'b0, 1'b1, 4'd3, 8'd2);
        start_req = 1'b1;
        step(1);
        start_req = 1'b0;
        step(11);
        start_req = 1'b1;
        expect_at(1, 8'd0, 1, 1, 1, "R8 collision keeps pulse");
        expect_at(5, 8'd1, 1, 0, 0, "R8 next rollover");
        step(7);

        if (q.size() != 0) begin
            bad += q.size();
            total += q.size();
            $display("FAIL unchecked items remain: actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule